// File: doc/BRIEF.md
# Synapse Event Address Decoder

This block is the digital half of one synapse-driver column in a spiking-network array. Two synapse rows share the driver, and each row spans every membrane column of its half-array. Each synapse keeps a programmable 4-bit source address and a 4-bit weight. Each synapse is also hard-wired to one of four strobe lines of the driver. A pre-synaptic event brings a 6-bit source address. The block splits that address into a strobe-line select and a match field. It then raises the selected strobe for a programmable number of cycles. For that window it drives a fire flag and the stored weight code for every synapse that is tied to that line and whose stored address equals the match field. The weight code stands in for the current a DAC would produce downstream.

A configuration port writes the address and weight of one synapse per cycle. Every pulse works from a snapshot taken when its event is accepted. A write therefore never disturbs a pulse in flight and is seen by the next event.

Top module: `syn_event_decoder`

## Requirements
- R1: After reset, strobe_o, fire_o and weight_o are all zero, and every stored synapse address and weight is zero.
- R2: An event is accepted when ev_valid is high at a clock edge while no strobe is active. ev_addr[5:4] selects the strobe line and ev_addr[3:0] is the match field.
- R3: The synapse in row r, column c is tied to strobe line 2*(r mod 2)+(c mod 2). It fires for an accepted event only if that line is selected and its stored address equals the match field.
- R4: During a pulse, strobe_o is one-hot with bit k set for selected line k. Outside a pulse, strobe_o is zero.
- R5: The pulse starts in the cycle after acceptance and lasts pulse_len cycles, with pulse_len sampled at acceptance. A pulse_len of 0 gives one cycle.
- R6: A firing synapse drives fire_o[r*NUM_COLS+c] high and presents its stored weight on weight_o[4*(r*NUM_COLS+c) +: 4]. This holds only while the strobe is high.
- R7: A synapse that does not fire drives fire flag 0 and weight code 0. All fire flags and weights are zero between pulses.
- R8: An event presented while a strobe is active is discarded and leaves the running pulse unchanged.
- R9: A write with cfg_we high stores cfg_addr and cfg_weight for synapse (cfg_row, cfg_col). Events accepted in later cycles see the new contents. An event accepted in the same cycle as the write uses the old contents. A write made during a pulse does not change that pulse's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event present |
| ev_addr | input | 6 | Event source address: line select [5:4], match field [3:0] |
| pulse_len | input | LEN_W | Strobe length in cycles (0 treated as 1) |
| cfg_we | input | 1 | Configuration write enable |
| cfg_row | input | ROW_W | Row of the synapse to write |
| cfg_col | input | COL_W | Column of the synapse to write |
| cfg_addr | input | 4 | Source address to store |
| cfg_weight | input | 4 | Weight to store |
| strobe_o | output | 4 | Strobe lines |
| fire_o | output | NUM_ROWS*NUM_COLS | Per-synapse fire flags |
| weight_o | output | 4*NUM_ROWS*NUM_COLS | Per-synapse weight codes |

## Verification
Several properties are checked on every cycle. The strobe is never more than one-hot. No fire flag is raised without a strobe. No weight appears on an unfired synapse. An accepted event raises exactly its selected line on the next cycle. Pulse outputs hold steady while the strobe stays high. Each pulse lasts exactly its sampled length. Only the bench scenarios can show the address matching itself. These scenarios compare whole fire and weight vectors against a reference memory across the strobe-line ties. They also cover a write that lands in the same cycle as an event, a write and a second event injected mid-pulse, and the zero-length pulse.

// File: rtl/syn_dec_pkg.sv
package syn_dec_pkg;
    localparam int EV_ADDR_W = 6;
    localparam int SEL_W     = 2;
    localparam int NUM_STB   = 1 << SEL_W;
    localparam int MATCH_W   = EV_ADDR_W - SEL_W;
    localparam int WGT_W     = 4;

    typedef logic [SEL_W-1:0]   sel_t;
    typedef logic [MATCH_W-1:0] match_t;
    typedef logic [WGT_W-1:0]   wgt_t;

    typedef struct packed {
        sel_t   sel;
        match_t match;
    } ev_fields_t;

    typedef enum logic {ST_IDLE, ST_PULSE} pstate_t;

    function automatic ev_fields_t split_ev(input logic [EV_ADDR_W-1:0] a);
        ev_fields_t f;
        f.sel   = a[EV_ADDR_W-1 -: SEL_W];
        f.match = a[MATCH_W-1:0];
        return f;
    endfunction

    // fixed strobe-line tie of a synapse
    function automatic sel_t tie_of(input int row, input int col);
        return sel_t'(((row % 2) * 2 + (col % 2)) % NUM_STB);
    endfunction
endpackage

// File: rtl/syn_cfg_store.sv
module syn_cfg_store
    import syn_dec_pkg::*;
#(
    parameter int NUM_ROWS = 2,
    parameter int NUM_COLS = 256,
    parameter int ROW_W    = 1,
    parameter int COL_W    = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we,
    input  logic [ROW_W-1:0]                row,
    input  logic [COL_W-1:0]                col,
    input  match_t                          addr_in,
    input  wgt_t                            wgt_in,
    output logic [NUM_ROWS*NUM_COLS*MATCH_W-1:0] addr_flat,
    output logic [NUM_ROWS*NUM_COLS*WGT_W-1:0]   wgt_flat
);
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
            localparam int IDX = r * NUM_COLS + c;
            logic hit;
            assign hit = we && (row == ROW_W'(r)) && (col == COL_W'(c));
            always_ff @(posedge clk) begin
                if (rst) begin
                    addr_flat[IDX*MATCH_W +: MATCH_W] <= '0;
                    wgt_flat[IDX*WGT_W +: WGT_W]      <= '0;
                end else if (hit) begin
                    addr_flat[IDX*MATCH_W +: MATCH_W] <= addr_in;
                    wgt_flat[IDX*WGT_W +: WGT_W]      <= wgt_in;
                end
            end
        end
    end
endmodule

// File: rtl/syn_pulse_timer.sv
module syn_pulse_timer
    import syn_dec_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ev_valid,
    input  sel_t               ev_sel,
    input  logic [LEN_W-1:0]   len,
    output logic               accept,
    output logic               active,
    output logic [NUM_STB-1:0] strobe
);
    pstate_t           state;
    logic [LEN_W-1:0]  cnt;
    sel_t              sel_q;

    assign accept = ev_valid && (state == ST_IDLE);
    assign active = (state == ST_PULSE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            sel_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state <= ST_PULSE;
                    cnt   <= (len == '0) ? LEN_W'(1) : len;
                    sel_q <= ev_sel;
                end
                ST_PULSE: begin
                    if (cnt == LEN_W'(1)) state <= ST_IDLE;
                    else                  cnt   <= cnt - LEN_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    for (genvar k = 0; k < NUM_STB; k++) begin : g_stb
        assign strobe[k] = active && (sel_q == sel_t'(k));
    end
endmodule

// File: rtl/syn_match_array.sv
module syn_match_array
    import syn_dec_pkg::*;
#(
    parameter int NUM_ROWS = 2,
    parameter int NUM_COLS = 256
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 load,
    input  logic                                 active,
    input  ev_fields_t                           ev,
    input  logic [NUM_ROWS*NUM_COLS*MATCH_W-1:0] addr_flat,
    input  logic [NUM_ROWS*NUM_COLS*WGT_W-1:0]   wgt_flat,
    output logic [NUM_ROWS*NUM_COLS-1:0]         fire,
    output logic [NUM_ROWS*NUM_COLS*WGT_W-1:0]   weight
);
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
            localparam int   IDX = r * NUM_COLS + c;
            localparam sel_t TIE = tie_of(r, c);
            logic hit;
            logic fire_q;
            wgt_t wgt_q;
            assign hit = (ev.sel == TIE) &&
                         (addr_flat[IDX*MATCH_W +: MATCH_W] == ev.match);
            always_ff @(posedge clk) begin
                if (rst) begin
                    fire_q <= 1'b0;
                    wgt_q  <= '0;
                end else if (load) begin
                    fire_q <= hit;
                    wgt_q  <= hit ? wgt_flat[IDX*WGT_W +: WGT_W] : '0;
                end
            end
            assign fire[IDX]                 = active && fire_q;
            assign weight[IDX*WGT_W +: WGT_W] = active ? wgt_q : '0;
        end
    end
endmodule

// File: rtl/syn_event_decoder.sv
module syn_event_decoder
    import syn_dec_pkg::*;
#(
    parameter int NUM_ROWS = 2,
    parameter int NUM_COLS = 256,
    parameter int LEN_W    = 4,
    localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
    localparam int COL_W   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
    localparam int NSYN    = NUM_ROWS * NUM_COLS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ev_valid,
    input  logic [EV_ADDR_W-1:0]   ev_addr,
    input  logic [LEN_W-1:0]       pulse_len,
    input  logic                   cfg_we,
    input  logic [ROW_W-1:0]       cfg_row,
    input  logic [COL_W-1:0]       cfg_col,
    input  logic [MATCH_W-1:0]     cfg_addr,
    input  logic [WGT_W-1:0]       cfg_weight,
    output logic [NUM_STB-1:0]     strobe_o,
    output logic [NSYN-1:0]        fire_o,
    output logic [NSYN*WGT_W-1:0]  weight_o
);
    ev_fields_t                 ev;
    logic                       accept;
    logic                       active;
    logic [NSYN*MATCH_W-1:0]    addr_flat;
    logic [NSYN*WGT_W-1:0]      wgt_flat;

    assign ev = split_ev(ev_addr);

    syn_cfg_store #(
        .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .ROW_W(ROW_W), .COL_W(COL_W)
    ) u_store (
        .clk(clk), .rst(rst), .we(cfg_we), .row(cfg_row), .col(cfg_col),
        .addr_in(cfg_addr), .wgt_in(cfg_weight),
        .addr_flat(addr_flat), .wgt_flat(wgt_flat)
    );

    syn_pulse_timer #(.LEN_W(LEN_W)) u_timer (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_sel(ev.sel),
        .len(pulse_len), .accept(accept), .active(active), .strobe(strobe_o)
    );

    syn_match_array #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_match (
        .clk(clk), .rst(rst), .load(accept), .active(active), .ev(ev),
        .addr_flat(addr_flat), .wgt_flat(wgt_flat),
        .fire(fire_o), .weight(weight_o)
    );
endmodule

// File: rtl/syn_event_decoder_chk.sv
module syn_event_decoder_chk
    import syn_dec_pkg::*;
#(
    parameter int NUM_ROWS = 2,
    parameter int NUM_COLS = 256,
    parameter int LEN_W    = 4,
    localparam int NSYN    = NUM_ROWS * NUM_COLS
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  ev_valid,
    input logic [EV_ADDR_W-1:0]  ev_addr,
    input logic [LEN_W-1:0]      pulse_len,
    input logic [NUM_STB-1:0]    strobe_o,
    input logic [NSYN-1:0]       fire_o,
    input logic [NSYN*WGT_W-1:0] weight_o
);
    logic [NSYN*WGT_W-1:0] unfired_w;
    logic [LEN_W:0]        run_cnt;
    logic [LEN_W:0]        len_q;

    always_comb begin
        for (int i = 0; i < NSYN; i++)
            unfired_w[i*WGT_W +: WGT_W] = fire_o[i] ? '0 : weight_o[i*WGT_W +: WGT_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            len_q   <= '0;
        end else begin
            run_cnt <= (|strobe_o) ? run_cnt + 1'b1 : '0;
            if (ev_valid && strobe_o == '0)
                len_q <= (pulse_len == '0) ? (LEN_W+1)'(1) : (LEN_W+1)'(pulse_len);
        end
    end

    a_r4_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_o));

    a_r2_accept_line: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && strobe_o == '0) |=>
            strobe_o == (NUM_STB'(1) << $past(ev_addr[EV_ADDR_W-1 -: SEL_W])));

    a_r5_pulse_len: assert property (@(posedge clk) disable iff (rst)
        $fell(|strobe_o) |-> run_cnt == len_q);

    a_r6_fire_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        (|fire_o) |-> (|strobe_o));

    a_r7_unfired_zero: assert property (@(posedge clk) disable iff (rst)
        unfired_w == '0);

    a_r8_pulse_steady: assert property (@(posedge clk) disable iff (rst)
        (|strobe_o) |=> (strobe_o == '0) ||
            ($stable(strobe_o) && $stable(fire_o) && $stable(weight_o)));
endmodule

bind syn_event_decoder syn_event_decoder_chk #(
    .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .LEN_W(LEN_W)
) u_chk (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_addr(ev_addr),
    .pulse_len(pulse_len), .strobe_o(strobe_o), .fire_o(fire_o),
    .weight_o(weight_o)
);

// File: tb/sim_syn_event_decoder.sv
module sim_syn_event_decoder;
    localparam int NR = 2;
    localparam int NC = 256;
    localparam int NS = NR * NC;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ev_valid = 1'b0;
    logic [5:0]      ev_addr = '0;
    logic [3:0]      pulse_len = '0;
    logic            cfg_we = 1'b0;
    logic            cfg_row = 1'b0;
    logic [7:0]      cfg_col = '0;
    logic [3:0]      cfg_addr = '0;
    logic [3:0]      cfg_weight = '0;
    logic [3:0]      strobe_o;
    logic [NS-1:0]   fire_o;
    logic [NS*4-1:0] weight_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [3:0] addr_m [NR][NC];
    logic [3:0] wgt_m  [NR][NC];
    logic [NS-1:0]   exp_fire;
    logic [NS*4-1:0] exp_wgt;

    syn_event_decoder u0 (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_addr(ev_addr),
        .pulse_len(pulse_len), .cfg_we(cfg_we), .cfg_row(cfg_row),
        .cfg_col(cfg_col), .cfg_addr(cfg_addr), .cfg_weight(cfg_weight),
        .strobe_o(strobe_o), .fire_o(fire_o), .weight_o(weight_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [2047:0] act, input logic [2047:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int tie(input int r, input int c);
        return (r % 2) * 2 + (c % 2);
    endfunction

    task automatic compute_exp(input logic [5:0] a);
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++) begin
                bit h = (tie(r, c) == int'(a[5:4])) && (addr_m[r][c] == a[3:0]);
                exp_fire[r*NC+c]      = h;
                exp_wgt[(r*NC+c)*4 +: 4] = h ? wgt_m[r][c] : 4'd0;
            end
    endtask

    task automatic do_write(input int r, input int c, input logic [3:0] a, input logic [3:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_row = r[0]; cfg_col = c[7:0]; cfg_addr = a; cfg_weight = w;
        @(negedge clk);
        cfg_we = 1'b0;
        addr_m[r][c] = a; wgt_m[r][c] = w;
    endtask

    // pick a synapse on the line selected by a, then load a write for it
    task automatic drive_tgt_write(input logic [5:0] a, output int r, output int c,
                                   output logic [3:0] wa, output logic [3:0] ww);
        r = $urandom_range(0, 1);
        c = ($urandom_range(0, NC/2 - 1) * 2) + (int'(a[4]));
        if ((r % 2) != int'(a[5])) r = int'(a[5]);
        wa = ($urandom_range(0, 1) == 1) ? a[3:0] : 4'($urandom_range(0, 15));
        ww = 4'($urandom_range(1, 15));
        cfg_we = 1'b1; cfg_row = r[0]; cfg_col = c[7:0]; cfg_addr = wa; cfg_weight = ww;
    endtask

    task automatic fire_event(input logic [5:0] a, input logic [3:0] len,
                              input bit inj_mid, input bit inj_same);
        int lf, r, c;
        logic [3:0] wa, ww;
        @(negedge clk);
        compute_exp(a);
        ev_valid = 1'b1; ev_addr = a; pulse_len = len;
        if (inj_same) drive_tgt_write(a, r, c, wa, ww);
        @(negedge clk);
        ev_valid = 1'b0; cfg_we = 1'b0;
        if (inj_same) begin addr_m[r][c] = wa; wgt_m[r][c] = ww; end
        lf = (len == 0) ? 1 : int'(len);
        for (int i = 0; i < lf; i++) begin
            check("R4", "strobe", 2048'(strobe_o), 2048'(4'b1 << a[5:4]));
            check(inj_same ? "R9" : "R3", "fire", 2048'(fire_o), 2048'(exp_fire));
            check(i > 0 && inj_mid ? "R8" : "R6", "weight", 2048'(weight_o), 2048'(exp_wgt));
            if (inj_mid && i == 0) begin
                drive_tgt_write(a, r, c, wa, ww);
                ev_valid = 1'b1; ev_addr = a ^ 6'h30; pulse_len = 4'd3;
            end
            @(negedge clk);
            if (inj_mid && i == 0) begin
                cfg_we = 1'b0; ev_valid = 1'b0;
                addr_m[r][c] = wa; wgt_m[r][c] = ww;
            end
        end
        check("R5", "strobe end", 2048'(strobe_o), 2048'(0));
        check("R7", "fire idle", 2048'(fire_o), 2048'(0));
        check("R7", "weight idle", 2048'(weight_o), 2048'(0));
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++) begin addr_m[r][c] = '0; wgt_m[r][c] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        check("R1", "strobe", 2048'(strobe_o), 2048'(0));
        check("R1", "fire", 2048'(fire_o), 2048'(0));
        check("R1", "weight", 2048'(weight_o), 2048'(0));
        // R1: stored contents zero -> match field 0 fires every tied synapse with weight 0
        fire_event(6'h20, 4'd2, 0, 0);
        // R9: write then event sees it; R3 ties checked over all four lines
        do_write(0, 10, 4'h5, 4'h9);
        do_write(1, 11, 4'h5, 4'hA);
        do_write(1, 10, 4'h5, 4'h3);
        for (int k = 0; k < 4; k++) fire_event({k[1:0], 4'h5}, 4'd1, 0, 0);
        // R5: zero length acts as one, maximum length fifteen
        fire_event(6'h05, 4'd0, 0, 0);
        fire_event(6'h35, 4'd15, 0, 0);
        // R8, R9: write and second event mid-pulse; R5 one-cycle pulse with dropped event
        fire_event(6'h25, 4'd4, 1, 0);
        fire_event(6'h25, 4'd1, 1, 0);
        // R9: write in the same cycle as the event uses old contents
        fire_event(6'h15, 4'd2, 0, 1);
        fire_event(6'h15, 4'd2, 0, 0);
        // random mix
        for (int n = 0; n < 200; n++) begin
            int nw = $urandom_range(0, 6);
            for (int j = 0; j < nw; j++)
                do_write($urandom_range(0, 1), $urandom_range(0, NC-1),
                         4'($urandom_range(0, 3)), 4'($urandom_range(0, 15)));
            fire_event(6'($urandom_range(0, 63)) & 6'h33, 4'($urandom_range(0, 6)),
                       $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule